// File: doc/BRIEF.md
# Key-Sequence Write Guard for a Configuration Register Bank

This block holds a small bank of configuration registers whose contents may only be changed after software has proven intent. A dedicated lock register at address 0x00 accepts an ordered three-byte key. After the full key has been written, the protected bank accepts writes. A single write whose low byte is zero closes the bank again. A second, smaller bank of ordinary registers is always writable. All registers sit on one simple synchronous bus with one address, a write strobe, write data, a read strobe and registered read data. Software that is unsure whether its key landed can read the lock register and repeat the whole key until the readback shows the bank open.

The key tracker is a four-state machine. `ST_LOCKED` means locked, with no key progress. `ST_KEY1_SEEN` means the first key has been accepted. `ST_KEY2_SEEN` means the second key has been accepted. `ST_OPEN` means the bank is unlocked. Transitions happen only on a write to address 0x00, and only bits [7:0] of the write data are compared:

- `ST_LOCKED` goes to `ST_KEY1_SEEN` on 0x59.
- `ST_KEY1_SEEN` goes to `ST_KEY2_SEEN` on 0x16, stays in `ST_KEY1_SEEN` on 0x59 (restart), and otherwise returns to `ST_LOCKED`.
- `ST_KEY2_SEEN` goes to `ST_OPEN` on 0x88, goes to `ST_KEY1_SEEN` on 0x59, and otherwise returns to `ST_LOCKED`.
- `ST_OPEN` returns to `ST_LOCKED` on 0x00. Any other lock write leaves it open.

Address map: the lock register is at 0x00. The protected registers are at 0x10 to 0x13, and the reset value of entry i is 0xC0DE0000 + i. The open registers are at 0x20 to 0x21, with reset value 0. Any other address reads as 0 and ignores writes.

Top module: `regwp_guard`

## Requirements
- R1: The reset is synchronous and active high. After reset the machine is in `ST_LOCKED`, `wr_blocked` is 0, `rd_data` is 0, the protected register at 0x10+i holds 0xC0DE0000+i, and the open registers hold 0.
- R2: Three consecutive writes to address 0x00, with low bytes 0x59, 0x16 and 0x88 in that order, unlock the bank from the cycle after the third write.
- R3: A read of address 0x00 returns 0x00000001 while the bank is unlocked. It returns 0x00000000 while the bank is locked, including while a key is partly entered.
- R4: While the bank is locked, a write to 0x10 to 0x13 leaves the register unchanged, and `wr_blocked` is 1 for exactly the one cycle after that write.
- R5: While the bank is unlocked, a write to 0x10 to 0x13 stores the write data, and `wr_blocked` stays 0.
- R6: While the bank is unlocked, a lock-register write with low byte 0x00 locks the bank from the next cycle. A lock write with any other low byte keeps it unlocked.
- R7: A lock write that does not match the next expected key clears the key progress. If that write's low byte is 0x59, it counts as the first key of a new attempt.
- R8: Only bits [7:0] of a lock-register write are compared. Bits above bit 7 are ignored.
- R9: Writes to any address other than 0x00 never change the key progress or the lock state.
- R10: Writes to 0x20 to 0x21 always store the write data, whatever the lock state.
- R11: A read returns, in the cycle after `rd_en`, the value the addressed register held before any write made in the same cycle. Protected registers are readable in any lock state. Unmapped addresses read 0. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| wr_blocked | output | 1 | One-cycle pulse after a protected write is dropped |

## Verification
The hardest state to reach from the ports is a partly entered key that is then disturbed. Examples are a second 0x59 after a first one, a wrong byte straight after 0x16, or an unrelated bus write between two keys. Each case must be followed by the rest of the key to show whether the progress survived. The stimulus interleaves writes to open and protected registers, and reads of the lock register, between key writes. It also sends keys with nonzero upper bits and wrong middle bytes. A behavioural model tracks progress as a plain counter and compares both outputs on every clock.

// File: rtl/regwp_pkg.sv
package regwp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED    = 2'd0,
        ST_KEY1_SEEN = 2'd1,
        ST_KEY2_SEEN = 2'd2,
        ST_OPEN      = 2'd3
    } guard_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'h59;
    localparam logic [7:0] KEY_SECOND = 8'h16;
    localparam logic [7:0] KEY_THIRD  = 8'h88;
    localparam logic [7:0] KEY_RELOCK = 8'h00;

endpackage

// File: rtl/regwp_key_fsm.sv
module regwp_key_fsm
    import regwp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         lock_wr,
    input  logic [7:0]   key_byte,
    output guard_state_t state,
    output logic         unlocked
);

    guard_state_t nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCKED;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (lock_wr) begin
            unique case (state)
                ST_LOCKED:
                    nxt = (key_byte == KEY_FIRST) ? ST_KEY1_SEEN : ST_LOCKED;
                ST_KEY1_SEEN:
                    if (key_byte == KEY_SECOND)     nxt = ST_KEY2_SEEN;
                    else if (key_byte == KEY_FIRST) nxt = ST_KEY1_SEEN;
                    else                            nxt = ST_LOCKED;
                ST_KEY2_SEEN:
                    if (key_byte == KEY_THIRD)      nxt = ST_OPEN;
                    else if (key_byte == KEY_FIRST) nxt = ST_KEY1_SEEN;
                    else                            nxt = ST_LOCKED;
                ST_OPEN:
                    nxt = (key_byte == KEY_RELOCK) ? ST_LOCKED : ST_OPEN;
                default: nxt = ST_LOCKED;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/regwp_bank.sv
module regwp_bank #(
    parameter int                 N_REGS   = 4,
    parameter int                 DATA_W   = 32,
    parameter logic [DATA_W-1:0]  RST_BASE = '0,
    localparam int                IDX_W    = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q [N_REGS]
);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= RST_BASE + DATA_W'(i);
            else if (wr && (idx == IDX_W'(i)))
                q[i] <= wdata;
        end
    end

endmodule

// File: rtl/regwp_guard.sv
module regwp_guard
    import regwp_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                N_PROT    = 4,
    parameter int                N_OPEN    = 2,
    parameter int                LOCK_ADDR = 'h00,
    parameter int                PROT_BASE = 'h10,
    parameter int                OPEN_BASE = 'h20,
    parameter logic [DATA_W-1:0] PROT_RST  = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_blocked
);

    localparam int PIDX_W = (N_PROT > 1) ? $clog2(N_PROT) : 1;
    localparam int OIDX_W = (N_OPEN > 1) ? $clog2(N_OPEN) : 1;
    localparam logic [ADDR_W-1:0] LOCK_A  = ADDR_W'(LOCK_ADDR);
    localparam logic [ADDR_W-1:0] PROT_LO = ADDR_W'(PROT_BASE);
    localparam logic [ADDR_W-1:0] PROT_HI = ADDR_W'(PROT_BASE + N_PROT);
    localparam logic [ADDR_W-1:0] OPEN_LO = ADDR_W'(OPEN_BASE);
    localparam logic [ADDR_W-1:0] OPEN_HI = ADDR_W'(OPEN_BASE + N_OPEN);

    guard_state_t       state;
    logic               unlocked;
    logic               lock_hit, prot_hit, open_hit;
    logic [ADDR_W-1:0]  prot_off, open_off;
    logic [PIDX_W-1:0]  prot_idx;
    logic [OIDX_W-1:0]  open_idx;
    logic [DATA_W-1:0]  prot_q [N_PROT];
    logic [DATA_W-1:0]  open_q [N_OPEN];
    logic [DATA_W-1:0]  rd_next;

    assign lock_hit = (addr == LOCK_A);
    assign prot_hit = (addr >= PROT_LO) && (addr < PROT_HI);
    assign open_hit = (addr >= OPEN_LO) && (addr < OPEN_HI);
    assign prot_off = addr - PROT_LO;
    assign open_off = addr - OPEN_LO;
    assign prot_idx = prot_off[PIDX_W-1:0];
    assign open_idx = open_off[OIDX_W-1:0];

    regwp_key_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lock_wr  (wr_en && lock_hit),
        .key_byte (wr_data[7:0]),
        .state    (state),
        .unlocked (unlocked)
    );

    regwp_bank #(.N_REGS(N_PROT), .DATA_W(DATA_W), .RST_BASE(PROT_RST)) u_prot (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en && prot_hit && unlocked),
        .idx   (prot_idx),
        .wdata (wr_data),
        .q     (prot_q)
    );

    regwp_bank #(.N_REGS(N_OPEN), .DATA_W(DATA_W), .RST_BASE('0)) u_open (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en && open_hit),
        .idx   (open_idx),
        .wdata (wr_data),
        .q     (open_q)
    );

    always_comb begin
        rd_next = '0;
        if (lock_hit)      rd_next = DATA_W'(unlocked);
        else if (prot_hit) rd_next = prot_q[prot_idx];
        else if (open_hit) rd_next = open_q[open_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            wr_blocked <= 1'b0;
        end else begin
            if (rd_en) rd_data <= rd_next;
            wr_blocked <= wr_en && prot_hit && !unlocked;
        end
    end

endmodule

// File: rtl/regwp_guard_chk.sv
module regwp_guard_chk
    import regwp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int N_PROT    = 4,
    parameter int LOCK_ADDR = 'h00,
    parameter int PROT_BASE = 'h10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input guard_state_t      state,
    input logic              unlocked,
    input logic              wr_blocked
);

    logic lock_w, prot_w;
    assign lock_w = wr_en && (addr == ADDR_W'(LOCK_ADDR));
    assign prot_w = wr_en && (addr >= ADDR_W'(PROT_BASE)) && (addr < ADDR_W'(PROT_BASE + N_PROT));

    p_unlock_key3_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(lock_w && wr_data[7:0] == KEY_THIRD && state == ST_KEY2_SEEN));

    p_locked_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (prot_w && !unlocked) |=> wr_blocked);

    p_no_flag_open_r5: assert property (@(posedge clk) disable iff (rst)
        (prot_w && unlocked) |=> !wr_blocked);

    p_relock_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_w && unlocked && wr_data[7:0] == KEY_RELOCK) |=> !unlocked);

    p_other_addr_r9: assert property (@(posedge clk) disable iff (rst)
        !lock_w |=> $stable(state));

endmodule

bind regwp_guard regwp_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PROT(N_PROT),
    .LOCK_ADDR(LOCK_ADDR), .PROT_BASE(PROT_BASE)
) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .state(state), .unlocked(unlocked), .wr_blocked(wr_blocked)
);

// File: tb/regwp_guard_bench.sv
`timescale 1ns/1ps
module regwp_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        wr_blocked;

    always #4 clk = ~clk;

    regwp_guard u_regwp_guard (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .wr_blocked(wr_blocked)
    );

    // behavioural reference
    byte unsigned keys[$] = '{8'h59, 8'h16, 8'h88};
    int          prog = 0;
    bit          m_open = 0;
    logic [31:0] m_prot [4];
    logic [31:0] m_opn  [2];
    logic [31:0] exp_rd = '0;
    bit          exp_blk = 0;
    string       req = "R1";
    int          n_tests = 0, n_fail = 0, cycles = 0;
    bit          done = 0;

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h00) return {31'd0, m_open};
        if (a >= 8'h10 && a < 8'h14) return m_prot[a - 8'h10];
        if (a >= 8'h20 && a < 8'h22) return m_opn[a - 8'h20];
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            prog = 0; m_open = 0; exp_rd = 0; exp_blk = 0;
            for (int i = 0; i < 4; i++) m_prot[i] = 32'hC0DE_0000 + i;
            for (int i = 0; i < 2; i++) m_opn[i] = 0;
        end else begin
            exp_blk = 0;
            if (rd_en) exp_rd = m_read(addr);
            if (wr_en) begin
                if (addr == 8'h00) begin
                    if (m_open) begin
                        if (wr_data[7:0] == 8'h00) begin m_open = 0; prog = 0; end
                    end else if (wr_data[7:0] == keys[prog]) begin
                        prog++;
                        if (prog == 3) begin m_open = 1; prog = 0; end
                    end else if (wr_data[7:0] == keys[0]) prog = 1;
                    else prog = 0;
                end else if (addr >= 8'h10 && addr < 8'h14) begin
                    if (m_open) m_prot[addr - 8'h10] = wr_data;
                    else exp_blk = 1;
                end else if (addr >= 8'h20 && addr < 8'h22) begin
                    m_opn[addr - 8'h20] = wr_data;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            n_tests++;
            if (rd_data !== exp_rd || wr_blocked !== exp_blk) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h blk=%b expected rd_data=%h blk=%b",
                         req, rd_data, wr_blocked, exp_rd, exp_blk);
            end
        end
        if (cycles > 50000 && !done) begin
            done = 1; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic bus(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d); bus(1, 0, a, d); endtask
    task automatic rd(input logic [7:0] a); bus(0, 1, a, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        req = "R1";  for (int i = 0; i < 4; i++) rd(8'h10 + i[7:0]); rd(8'h00); rd(8'h20);
        req = "R4";  wr(8'h11, 32'h1111_1111); wr(8'h12, 32'h2); wr(8'h13, 32'h3); rd(8'h11); rd(8'h12);
        req = "R3";  wr(8'h00, 32'h59); rd(8'h00); wr(8'h00, 32'h16); rd(8'h00);
        req = "R2";  wr(8'h00, 32'h88); rd(8'h00);
        req = "R5";  wr(8'h11, 32'hAAAA_5555); rd(8'h11); bus(1, 1, 8'h12, 32'h77); rd(8'h12);
        req = "R6";  wr(8'h00, 32'h59); rd(8'h00); wr(8'h00, 32'h0); rd(8'h00); wr(8'h10, 32'hDEAD); rd(8'h10);
        req = "R7";  wr(8'h00, 32'h59); wr(8'h00, 32'h16); wr(8'h00, 32'h77); wr(8'h00, 32'h16);
                     wr(8'h00, 32'h88); rd(8'h00);
                     wr(8'h00, 32'h59); wr(8'h00, 32'h16); wr(8'h00, 32'h59); wr(8'h00, 32'h16);
                     wr(8'h00, 32'h88); rd(8'h00); wr(8'h00, 32'h0);
                     wr(8'h00, 32'h59); wr(8'h00, 32'h59); wr(8'h00, 32'h16); wr(8'h00, 32'h88); rd(8'h00);
                     wr(8'h00, 32'h0);
        req = "R8";  wr(8'h00, 32'hFFFF_FF59); wr(8'h00, 32'h0000_1216); wr(8'h00, 32'h00AB_CD88); rd(8'h00);
                     wr(8'h00, 32'h0000_0100); rd(8'h00);
        req = "R9";  wr(8'h00, 32'h59); wr(8'h21, 32'h1234); rd(8'h13); wr(8'h00, 32'h16);
                     wr(8'h10, 32'h5); wr(8'h30, 32'h88); wr(8'h00, 32'h88); rd(8'h00);
                     wr(8'h13, 32'hCAFE); rd(8'h13); wr(8'h00, 32'h0);
        req = "R10"; wr(8'h20, 32'hBEEF); wr(8'h21, 32'hF00D); rd(8'h20); rd(8'h21);
        req = "R11"; rd(8'h30); bus(0, 0, 8'h20, 0); bus(0, 0, 8'h00, 0); bus(1, 1, 8'h20, 32'h9); rd(8'h20);
                     rd(8'h12);
        bus(0, 0, 8'h00, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule